// File: doc/BRIEF.md
# Flash program/erase command sequencer

This block sits on the host side of a parallel NOR flash and turns one request into the full unlock-and-command write train the memory expects. A request names one of four operations: program a byte, erase a sector, erase a block or erase the whole chip. It carries a byte address and, for a program, a data byte. The sequencer places one write per cycle on a simple synchronous bus. It then reads the location of its last write again and again until bit 6 of the returned data stops changing.

Because the memory may finish its internal operation in the middle of a poll, one matching pair of reads is not trusted. Two further reads must agree with that pair before the sequencer declares success. Each operation type has its own limit in clock cycles. If polling outlasts that limit, the sequencer finishes with an error flag instead. Requests use a valid/ready handshake, and a new request is taken only when the sequencer is idle.

Top module: `nvm_cmd_sequencer`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `bus_wr`, `bus_rd`, `done` and `err` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the cycle after acceptance until the `done` cycle, `req_ready` is 0, and any change on the request inputs has no effect on the bus traffic.
- R3: A program request (`req_op` = 0) produces four writes in consecutive cycles, starting in the cycle after acceptance. These are AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R4: An erase request produces six writes in consecutive cycles. These are AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h and 55h/2AAAh, then a final code: 30h for sector erase (`req_op` = 1), 50h for block erase (`req_op` = 2), or 10h for chip erase (`req_op` = 3).
- R5: The final erase write goes to the request address with its low `SEC_BITS` bits cleared for a sector, or its low `BLK_BITS` bits cleared for a block. For a chip erase it goes to 5555h.
- R6: Polling starts in the cycle after the final write. A read strobe is issued every second cycle to the address of the final write, and `bus_rd` and `bus_wr` are never high together.
- R7: Read data is taken in the cycle after its strobe, and only bit 6 is examined. Completion is declared only after four consecutive reads return the same bit 6. Any difference restarts the count from the newest read.
- R8: Poll cycles are counted from the first read strobe, which is count 0, so the capture of the j-th read sees count 2j-1. If a capture does not complete the operation and the count has reached the limit for the operation type, the sequencer finishes with `err` = 1. The limits are `TO_PROG` for program, `TO_SECBLK` for sector and block erase, and `TO_CHIP` for chip erase.
- R9: When the capture that completes the operation is also the one at which the limit is reached, completion wins and `err` stays 0.
- R10: `done` is a one-cycle pulse in the cycle after the deciding capture. `req_ready` is 1 in that cycle, and `err` is only ever 1 together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| done | output | 1 | Operation finished (pulse) |
| err | output | 1 | Finished by timeout (with `done`) |

## Verification
Completion and timeout can be decided by the same read capture. The bench provokes this by choosing how many times the responder flips bit 6, so that the fourth equal read lands exactly on the capture where the poll count reaches the limit. In that case it expects `done` with `err` low. With one more flip, the same capture must give `err` high. A responder pattern with stalled flips creates false matching pairs, and the bench then checks that the two confirming reads reject them and polling continues.

// File: rtl/nvm_cmd_sequencer.sv
module nvm_cmd_sequencer #(
  parameter int AW        = 20,
  parameter int SEC_BITS  = 12,
  parameter int BLK_BITS  = 16,
  parameter int TO_PROG   = 5000,
  parameter int TO_SECBLK = 6250000,
  parameter int TO_CHIP   = 25000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic          err
);
  localparam int MAX_A = (TO_PROG > TO_SECBLK) ? TO_PROG : TO_SECBLK;
  localparam int MAX_TO = (MAX_A > TO_CHIP) ? MAX_A : TO_CHIP;
  localparam int TW = $clog2(MAX_TO + 1) + 1;
  localparam logic [AW-1:0] ADR_HI = AW'(15'h5555);
  localparam logic [AW-1:0] ADR_LO = AW'(15'h2AAA);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_CAP} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step;
  logic [TW-1:0] tmr;
  logic [2:0]    run;
  logic          prev6;
  logic          done_q, err_q;

  logic [AW-1:0] fin_addr, wr_addr;
  logic [7:0]    fin_data, wr_data;
  logic [TW-1:0] lim;
  logic [2:0]    run_nxt;

  wire is_prog   = (op_q == 2'd0);
  wire [2:0] last_step = is_prog ? 3'd3 : 3'd5;
  wire b6        = bus_rdata[6];
  wire complete  = (run_nxt == 3'd4);
  wire expire    = (tmr >= lim);

  assign req_ready = (st == S_IDLE);
  assign bus_wr    = (st == S_WR);
  assign bus_rd    = (st == S_RD);
  assign bus_addr  = (st == S_WR) ? wr_addr : fin_addr;
  assign bus_wdata = wr_data;
  assign done      = done_q;
  assign err       = err_q;
  assign run_nxt   = (run == 3'd0) ? 3'd1 : ((b6 == prev6) ? run + 3'd1 : 3'd1);

  always_comb begin
    case (op_q)
      2'd0:    begin fin_addr = addr_q; fin_data = data_q; end
      2'd1:    begin fin_addr = {addr_q[AW-1:SEC_BITS], {SEC_BITS{1'b0}}}; fin_data = 8'h30; end
      2'd2:    begin fin_addr = {addr_q[AW-1:BLK_BITS], {BLK_BITS{1'b0}}}; fin_data = 8'h50; end
      default: begin fin_addr = ADR_HI; fin_data = 8'h10; end
    endcase
  end

  always_comb begin
    case (op_q)
      2'd0:    lim = TW'(TO_PROG);
      2'd3:    lim = TW'(TO_CHIP);
      default: lim = TW'(TO_SECBLK);
    endcase
  end

  always_comb begin
    case (step)
      3'd0:    begin wr_addr = ADR_HI; wr_data = 8'hAA; end
      3'd1:    begin wr_addr = ADR_LO; wr_data = 8'h55; end
      3'd2:    begin wr_addr = ADR_HI; wr_data = is_prog ? 8'hA0 : 8'h80; end
      3'd3:    begin wr_addr = is_prog ? fin_addr : ADR_HI; wr_data = is_prog ? fin_data : 8'hAA; end
      3'd4:    begin wr_addr = ADR_LO; wr_data = 8'h55; end
      default: begin wr_addr = fin_addr; wr_data = fin_data; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      step   <= '0;
      tmr    <= '0;
      run    <= '0;
      prev6  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          step   <= '0;
          st     <= S_WR;
        end
        S_WR: if (step == last_step) begin
          tmr <= '0;
          run <= '0;
          st  <= S_RD;
        end else begin
          step <= step + 3'd1;
        end
        S_RD: begin
          tmr <= tmr + TW'(1);
          st  <= S_CAP;
        end
        default: begin
          tmr   <= tmr + TW'(1);
          run   <= run_nxt;
          prev6 <= b6;
          if (complete) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (expire) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
      endcase
    end
  end
endmodule

module nvm_cmd_sequencer_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          done,
  input logic          err
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, bus_rd}));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_wr && !bus_rd));
  assert_first_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_wr && bus_wdata == 8'hAA && bus_addr == AW'(15'h5555)));
  assert_read_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (!bus_rd && !bus_wr));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nvm_cmd_sequencer nvm_cmd_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .done(done), .err(err)
);

// File: tb/nvm_cmd_sequencer_tb.sv
module nvm_cmd_sequencer_tb;
  localparam int AW = 20;
  localparam int L_PROG = 21;
  localparam int L_SB = 31;
  localparam int L_CHIP = 41;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;
  logic          done, err;

  nvm_cmd_sequencer #(.AW(AW), .TO_PROG(L_PROG), .TO_SECBLK(L_SB), .TO_CHIP(L_CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .err(err));

  int n_chk = 0;
  int n_fail = 0;

  // status responder: flips bit 6 on reads whose mask bit is set
  logic [63:0] tmask = '0;
  int rd_n = 0;
  int rd_base = 0;
  logic t6 = 1'b0;
  always @(posedge clk) if (bus_rd) begin
    t6        <= t6 ^ tmask[(rd_n - rd_base) & 63];
    bus_rdata <= {1'b0, t6 ^ tmask[(rd_n - rd_base) & 63], 6'h15};
    rd_n      <= rd_n + 1;
  end

  // per-cycle reference expectations
  logic e_wr, e_rd, e_ready, e_done, e_err;
  logic [AW-1:0] e_addr = '0;
  logic [7:0] e_wdata = '0;
  string e_tag = "R1";
  bit chk_en = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check(e_tag, "req_ready", 32'(req_ready), 32'(e_ready));
    check(e_tag, "bus_wr", 32'(bus_wr), 32'(e_wr));
    check(e_tag, "bus_rd", 32'(bus_rd), 32'(e_rd));
    check(e_tag, "done", 32'(done), 32'(e_done));
    check(e_tag, "err", 32'(err), 32'(e_err));
    if (e_wr) begin
      check(e_tag, "write addr", 32'(bus_addr), 32'(e_addr));
      check(e_tag, "write data", 32'(bus_wdata), 32'(e_wdata));
    end
    if (e_rd) check(e_tag, "poll addr", 32'(bus_addr), 32'(e_addr));
  end

  task automatic set_idle();
    e_wr = 1'b0; e_rd = 1'b0; e_ready = 1'b1; e_done = 1'b0; e_err = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [63:0] m, input bit hold, input string tag);
    logic [AW-1:0] wa[6];
    logic [7:0] wd[6];
    logic [AW-1:0] fa;
    logic [7:0] fd;
    int nw, lim, k, jerr, jend, run;
    logic v, pv, e;
    case (op)
      2'd0: begin fa = a; fd = d; lim = L_PROG; end
      2'd1: begin fa = a & ~AW'(20'hFFF); fd = 8'h30; lim = L_SB; end
      2'd2: begin fa = a & ~AW'(20'hFFFF); fd = 8'h50; lim = L_SB; end
      default: begin fa = AW'(20'h05555); fd = 8'h10; lim = L_CHIP; end
    endcase
    wa[0] = AW'(20'h05555); wd[0] = 8'hAA;
    wa[1] = AW'(20'h02AAA); wd[1] = 8'h55;
    wa[2] = AW'(20'h05555); wd[2] = (op == 2'd0) ? 8'hA0 : 8'h80;
    if (op == 2'd0) begin
      nw = 4; wa[3] = fa; wd[3] = fd;
      wa[4] = '0; wd[4] = '0; wa[5] = '0; wd[5] = '0;
    end else begin
      nw = 6;
      wa[3] = AW'(20'h05555); wd[3] = 8'hAA;
      wa[4] = AW'(20'h02AAA); wd[4] = 8'h55;
      wa[5] = fa; wd[5] = fd;
    end
    // expected completion read: first read ending a run of four equal bit-6 values
    v = t6; pv = 1'b0; run = 0; k = 64;
    for (int n = 1; n < 64; n++) begin
      v = v ^ m[n-1];
      run = (n == 1 || v != pv) ? 1 : run + 1;
      pv = v;
      if (run == 4) begin k = n; break; end
    end
    jerr = (lim + 2) / 2;
    jend = (k <= jerr) ? k : jerr;
    e = (k > jerr);

    @(posedge clk); #1;
    set_idle(); e_tag = tag;
    tmask = m; rd_base = rd_n;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    for (int s = 0; s < nw; s++) begin
      @(posedge clk); #1;
      if (hold) begin req_op = ~op; req_addr = ~a; req_data = ~d; end
      else req_valid = 1'b0;
      e_ready = 1'b0; e_wr = 1'b1; e_addr = wa[s]; e_wdata = wd[s];
    end
    for (int j = 1; j <= jend; j++) begin
      @(posedge clk); #1;
      e_wr = 1'b0; e_rd = 1'b1; e_addr = fa;
      @(posedge clk); #1;
      e_rd = 1'b0;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    e_ready = 1'b1; e_done = 1'b1; e_err = e;
    @(posedge clk); #1;
    set_idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog R10: actual hung expected done");
    finish_run();
  end

  initial begin
    set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while held in reset
    check("R1", "ready in reset", 32'(req_ready), 32'd1);
    check("R1", "wr in reset", 32'(bus_wr), 32'd0);
    check("R1", "rd in reset", 32'(bus_rd), 32'd0);
    check("R1", "done in reset", 32'(done), 32'd0);
    check("R1", "err in reset", 32'(err), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    e_tag = "R1"; chk_en = 1'b1;
    @(posedge clk); #1;

    run_op(2'd0, AW'(20'h12345), 8'h3C, 64'h0, 1'b0, "R3/R6/R7 program stable");
    run_op(2'd0, AW'(20'hFEDCB), 8'hC3, 64'h7, 1'b0, "R3/R7 program busy");
    run_op(2'd1, AW'(20'hABCDE), 8'h00, 64'h1F, 1'b0, "R4/R5 sector erase");
    run_op(2'd2, AW'(20'h7FFFF), 8'h00, 64'h3F, 1'b0, "R4/R5 block erase");
    run_op(2'd3, AW'(20'h9ABCD), 8'h00, 64'h3FF, 1'b0, "R4/R5 chip erase");
    run_op(2'd0, AW'(20'h00010), 8'h5A, 64'h1B, 1'b0, "R7 false pair rejected");
    run_op(2'd0, AW'(20'h00020), 8'hA5, 64'h9, 1'b0, "R7 triple run rejected");
    run_op(2'd0, AW'(20'h00030), 8'h11, 64'hFFFFF, 1'b0, "R8 program timeout");
    run_op(2'd0, AW'(20'h00040), 8'h22, 64'hFF, 1'b0, "R9 program tie");
    run_op(2'd0, AW'(20'h00050), 8'h33, 64'h1FF, 1'b0, "R8 program one past");
    run_op(2'd1, AW'(20'h45678), 8'h00, 64'h3FFF, 1'b0, "R8 sector timeout");
    run_op(2'd2, AW'(20'h45678), 8'h00, 64'h1FFF, 1'b0, "R9 block tie");
    run_op(2'd3, AW'(20'h00000), 8'h00, 64'h1FFFFFF, 1'b0, "R8 chip timeout");
    run_op(2'd1, AW'(20'h31415), 8'h00, 64'h3, 1'b1, "R2 request held while busy");
    run_op(2'd0, AW'(20'h00060), 8'h44, 64'h1, 1'b0, "R10 done pulse");

    @(posedge clk); #1;
    chk_en = 1'b0;
    finish_run();
  end
endmodule